// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block holds the program counter of a 32-bit fetch stage. It picks the next fetch address once per clock. The choices are the sequential successor, a PC-relative conditional branch, a direct jump inside the current 256 MB region, a jump that records a return address, and a jump to an address taken from a register. The decoder gives it a small operation code. The datapath gives it the branch offset field, the 26-bit jump field, the result of the register-equality comparison and the register value used for register jumps.

When the operation is a jump that records a return address, the block raises a write strobe for the register file. With that strobe it presents the address of the following instruction, which is to be stored in register 31. A stall input freezes the counter. A synchronous reset returns the counter to a parameterised start address, which is zero by default.

Top module: `next_pc_unit`

## Requirements
- R1: When `rst` is high at a rising edge, `pc` becomes RESET_PC (default 0) after that edge, whatever the other inputs are.
- R2: With `rst` low and `stall` low, operation code 0 (sequential) advances `pc` by 4. Codes 6 and 7 are unused and behave the same way.
- R3: Code 1 (branch-if-equal) loads `pc + 4 + 4*sext(br_off)` when `ops_equal` is 1. Otherwise it loads `pc + 4`.
- R4: Code 2 (branch-if-not-equal) loads `pc + 4 + 4*sext(br_off)` when `ops_equal` is 0. Otherwise it loads `pc + 4`.
- R5: The branch offset is a signed 16-bit word count. Both the largest positive value (0x7FFF) and the most negative value (0x8000) move `pc` by that many words relative to `pc + 4`.
- R6: Code 3 (direct jump) loads `{(pc+4)[31:28], jmp_field, 2'b00}`. The top four bits are taken from `pc + 4`, even when that addition crosses a 256 MB boundary.
- R7: Code 4 (jump-and-link) loads the same target as code 3.
- R8: `link_addr` always shows `pc + 4`. `link_we` is 1 only in a cycle where the code is 4, `stall` is low and `rst` is low, and it is 0 in every other cycle.
- R9: Code 5 (register jump) loads `jr_value` unchanged.
- R10: With `rst` low, `stall` high keeps `pc` unchanged for every operation code, and `link_we` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Hold the counter this cycle |
| op | input | 3 | 0 seq, 1 branch-eq, 2 branch-ne, 3 jump, 4 jump-and-link, 5 register jump |
| br_off | input | 16 | Signed branch offset in words |
| jmp_field | input | 26 | Word-address field of a direct jump |
| ops_equal | input | 1 | 1 when the two compared registers are equal |
| jr_value | input | 32 | Target for a register jump |
| pc | output | 32 | Current fetch address |
| link_addr | output | 32 | Return address, pc + 4 |
| link_we | output | 1 | Write strobe for the return address into register 31 |

## Verification
The assertions assume that `op`, `ops_equal` and the target fields are known (not X) whenever reset is low, and that reset is held through the first clock edge. The bench drives every input at the falling edge, starting from time zero, so all inputs are defined before the first rising edge. It releases reset only after two edges. The stimulus also brings the counter close to a 256 MB boundary through a register jump before it issues direct jumps, so that the region-bit corner is actually reached.

// File: rtl/next_pc_unit.sv
module next_pc_unit #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        stall,
  input  logic [2:0]  op,
  input  logic [15:0] br_off,
  input  logic [25:0] jmp_field,
  input  logic        ops_equal,
  input  logic [31:0] jr_value,
  output logic [31:0] pc,
  output logic [31:0] link_addr,
  output logic        link_we
);
  localparam logic [2:0] OP_SEQ = 3'd0;
  localparam logic [2:0] OP_BEQ = 3'd1;
  localparam logic [2:0] OP_BNE = 3'd2;
  localparam logic [2:0] OP_JMP = 3'd3;
  localparam logic [2:0] OP_JAL = 3'd4;
  localparam logic [2:0] OP_JR  = 3'd5;

  logic [31:0] pc_q, seq_pc, br_pc, jmp_pc, nxt_pc;
  logic        take_br;

  assign seq_pc  = pc_q + 32'd4;
  assign br_pc   = seq_pc + {{14{br_off[15]}}, br_off, 2'b00};
  assign jmp_pc  = {seq_pc[31:28], jmp_field, 2'b00};
  assign take_br = (op == OP_BEQ && ops_equal) || (op == OP_BNE && !ops_equal);

  always_comb begin
    case (op)
      OP_BEQ, OP_BNE: nxt_pc = take_br ? br_pc : seq_pc;
      OP_JMP, OP_JAL: nxt_pc = jmp_pc;
      OP_JR:          nxt_pc = jr_value;
      default:        nxt_pc = seq_pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         pc_q <= RESET_PC;
    else if (!stall) pc_q <= nxt_pc;
  end

  assign pc        = pc_q;
  assign link_addr = seq_pc;
  assign link_we   = (op == OP_JAL) && !stall && !rst;
endmodule

// File: rtl/next_pc_unit_chk.sv
module next_pc_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        stall,
  input logic [2:0]  op,
  input logic [25:0] jmp_field,
  input logic        ops_equal,
  input logic [31:0] jr_value,
  input logic [31:0] pc,
  input logic [31:0] link_addr,
  input logic        link_we
);
  logic seen_clk = 1'b0;
  always_ff @(posedge clk) seen_clk <= 1'b1;

  // R1
  reset_value_chk: assert property (@(posedge clk) seen_clk && rst |=> pc == 32'h0);

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    !stall && (op == 3'd0 || op == 3'd6 || op == 3'd7) |=> pc == $past(pc) + 32'd4);

  // R6
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    !stall && op == 3'd3 |=> pc[27:0] == {$past(jmp_field), 2'b00});

  // R8
  link_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    link_we |-> op == 3'd4 && !stall);

  // R8
  link_value_chk: assert property (@(posedge clk) disable iff (rst)
    link_addr - pc == 32'd4);

  // R9
  reg_jump_chk: assert property (@(posedge clk) disable iff (rst)
    !stall && op == 3'd5 |=> pc == $past(jr_value));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(pc));
endmodule

bind next_pc_unit next_pc_unit_chk i_chk (
  .clk(clk), .rst(rst), .stall(stall), .op(op), .jmp_field(jmp_field),
  .ops_equal(ops_equal), .jr_value(jr_value), .pc(pc),
  .link_addr(link_addr), .link_we(link_we)
);

// File: tb/test_next_pc_unit.sv
module test_next_pc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [15:0] br_off = 16'h0;
  logic [25:0] jmp_field = 26'h0;
  logic        ops_equal = 1'b0;
  logic [31:0] jr_value = 32'h0;
  logic [31:0] pc, link_addr;
  logic        link_we;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [31:0] m_pc = 32'h0;

  always #10 clk = ~clk;

  next_pc_unit i_next_pc_unit (
    .clk(clk), .rst(rst), .stall(stall), .op(op), .br_off(br_off),
    .jmp_field(jmp_field), .ops_equal(ops_equal), .jr_value(jr_value),
    .pc(pc), .link_addr(link_addr), .link_we(link_we)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic r, input logic s, input logic [2:0] o,
                      input logic [15:0] off, input logic [25:0] jf, input logic eq,
                      input logic [31:0] jv);
    int offw;
    logic [31:0] nxt;
    rst = r; stall = s; op = o; br_off = off; jmp_field = jf; ops_equal = eq; jr_value = jv;
    #1;
    check({req, " R8 link_addr"}, link_addr, m_pc + 32'd4);
    check({req, " R8 link_we"}, {31'd0, link_we}, {31'd0, (o == 3'd4 && !s && !r)});
    @(posedge clk);
    offw = $signed(off);
    case (o)
      3'd1: nxt = eq ? m_pc + 32'd4 + 32'(offw * 4) : m_pc + 32'd4;
      3'd2: nxt = !eq ? m_pc + 32'd4 + 32'(offw * 4) : m_pc + 32'd4;
      3'd3, 3'd4: nxt = ((m_pc + 32'd4) & 32'hF000_0000) | (32'(jf) * 32'd4);
      3'd5: nxt = jv;
      default: nxt = m_pc + 32'd4;
    endcase
    if (r) m_pc = 32'h0;
    else if (!s) m_pc = nxt;
    @(negedge clk);
    check(req, pc, m_pc);
  endtask

  initial begin
    @(negedge clk);
    step("R1 reset", 1, 0, 3'd5, 16'h0, 26'h0, 0, 32'h1234);
    step("R1 reset hold", 1, 1, 3'd3, 16'h0, 26'h155, 1, 32'h0);
    step("R2 seq", 0, 0, 3'd0, 16'h0, 26'h0, 0, 32'h0);
    step("R2 seq", 0, 0, 3'd0, 16'h9, 26'h3, 1, 32'hFFFF);
    step("R2 unused 6", 0, 0, 3'd6, 16'h40, 26'h0, 1, 32'h0);
    step("R2 unused 7", 0, 0, 3'd7, 16'h40, 26'h0, 0, 32'h0);
    step("R3 beq taken", 0, 0, 3'd1, 16'h0010, 26'h0, 1, 32'h0);
    step("R3 beq not taken", 0, 0, 3'd1, 16'h0010, 26'h0, 0, 32'h0);
    step("R4 bne taken", 0, 0, 3'd2, 16'hFFFD, 26'h0, 0, 32'h0);
    step("R4 bne not taken", 0, 0, 3'd2, 16'h0100, 26'h0, 1, 32'h0);
    step("R5 max offset", 0, 0, 3'd1, 16'h7FFF, 26'h0, 1, 32'h0);
    step("R5 min offset", 0, 0, 3'd2, 16'h8000, 26'h0, 0, 32'h0);
    step("R10 stall beq", 0, 1, 3'd1, 16'h0040, 26'h0, 1, 32'h0);
    step("R10 stall jal", 0, 1, 3'd4, 16'h0, 26'h123, 0, 32'h0);
    step("R10 stall jr", 0, 1, 3'd5, 16'h0, 26'h0, 0, 32'h8888_0000);
    step("R9 reg jump", 0, 0, 3'd5, 16'h0, 26'h0, 0, 32'hA000_0010);
    step("R6 jump keep region", 0, 0, 3'd3, 16'h0, 26'h2AA_AAAA, 0, 32'h0);
    step("R7 jal", 0, 0, 3'd4, 16'h0, 26'h000_0100, 0, 32'h0);
    step("R9 reg jump near boundary", 0, 0, 3'd5, 16'h0, 26'h0, 0, 32'h1FFF_FFFC);
    step("R6 jump across boundary", 0, 0, 3'd3, 16'h0, 26'h000_0008, 0, 32'h0);
    step("R9 reg jump near boundary", 0, 0, 3'd5, 16'h0, 26'h0, 0, 32'h6FFF_FFFC);
    step("R7 jal across boundary", 0, 0, 3'd4, 16'h0, 26'h3FF_FFFF, 0, 32'h0);
    step("R2 after jal", 0, 0, 3'd0, 16'h0, 26'h0, 0, 32'h0);
    step("R1 reset mid run", 1, 0, 3'd4, 16'h0, 26'h55, 0, 32'h0);
    step("R2 seq after reset", 0, 0, 3'd0, 16'h0, 26'h0, 0, 32'h0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule